// File: doc/BRIEF.md
# Page protection permission evaluator

This block decides which access rights a translated page grants and whether a requested access may go ahead. It takes the protection fields of a page table entry (second word), the protection key bits and no-execute bit of the matching segment entry, the current privilege state, and a per-key authority mask register. From these it forms two independent rights sets. The page-protection set comes from a 3-bit protection code read through one of two tables, chosen by the segment key. The authority-mask set comes from a 2-bit field of the mask register, selected by the page's 5-bit key. The two sets are ANDed together.

The final rights are then checked against the requested access type. The block reports a violation, and separately says whether the page-protection stage or the authority-mask stage lacked the needed right. A fault handler can then build its status word from these flags. The block is purely combinational. It sits after the table walk and ahead of fault reporting, and does neither.

Top module: `perm_eval`

## Requirements
- R1: The active key is `seg_key_user_i` when `prob_state_i` is 1 and `seg_key_sup_i` when it is 0.
- R2: The protection code is {`pte_w1_i[63]`, `pte_w1_i[1:0]`}. With active key 0: codes 0, 1 and 2 grant read and write; codes 3 and 6 grant read only; codes 4, 5 and 7 grant neither.
- R3: With active key 1: code 2 grants read and write; codes 1 and 3 grant read only; codes 0, 4, 5, 6 and 7 grant neither.
- R4: The page-protection stage grants execute only when `pte_w1_i[2]` (no-execute), `pte_w1_i[3]` (guarded) and `seg_noexec_i` are all 0.
- R5: With `mask_en_i` = 1, the page key k = `pte_w1_i[13:9]` selects mask bits [2*(31-k)+1 : 2*(31-k)]. The upper bit permits write, the lower bit permits read, and execute is always permitted by this stage.
- R6: With `mask_en_i` = 0, the authority-mask stage permits read, write and execute.
- R7: `grant_o` (bit 0 read, bit 1 write, bit 2 execute) is the bitwise AND of the two stages.
- R8: The access type (0 read, 1 write, 2 fetch) needs the right at bit 0, 1 or 2 of `grant_o`. `viol_o` is 1 exactly when that right is missing. `pp_fail_o` / `mask_fail_o` are 1 when the page-protection / authority-mask stage lacks it.
- R9: Access type 3 sets `bad_type_o` and `viol_o` and clears `pp_fail_o` and `mask_fail_o`. For types 0 to 2, `bad_type_o` is 0.
- R10: Bits of `pte_w1_i` outside 63, 13:9, 3, 2, 1 and 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prob_state_i | input | 1 | 1 = user (problem) state, 0 = supervisor |
| seg_key_user_i | input | 1 | Segment key used in user state |
| seg_key_sup_i | input | 1 | Segment key used in supervisor state |
| seg_noexec_i | input | 1 | Segment no-execute flag |
| pte_w1_i | input | 64 | Page table entry second word |
| auth_mask_i | input | 64 | Authority mask register, 2 bits per key |
| mask_en_i | input | 1 | Enables the authority-mask stage |
| acc_type_i | input | 2 | 0 read, 1 write, 2 fetch, 3 illegal |
| grant_o | output | 3 | Granted rights {exec, write, read} |
| viol_o | output | 1 | Requested access not permitted |
| pp_fail_o | output | 1 | Page-protection stage lacks needed right |
| mask_fail_o | output | 1 | Authority-mask stage lacks needed right |
| bad_type_o | output | 1 | Illegal access type presented |

## Verification
The bench sweeps every combination of privilege state, both segment keys, segment no-execute, all eight protection codes, the no-execute and guarded bits, mask enable and all four access types. Outputs are compared against a table model computed in the bench. When the two segment keys differ, the sweep shows that the right key was picked. The reserved codes and the key 1 table show the two tables apart.

A second sweep walks all 32 page keys with all four field values. The other mask fields hold the complement, so a wrong field index or a swapped read/write bit gives a different grant. A last pass fills the unused entry bits with noise and expects outputs identical to a clean entry.

// File: rtl/perm_pkg.sv
package perm_pkg;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;

  localparam rights_t RIGHTS_NONE = '{x: 1'b0, w: 1'b0, r: 1'b0};
  localparam rights_t RIGHTS_ALL  = '{x: 1'b1, w: 1'b1, r: 1'b1};

  // Right demanded by an access type; none for the illegal code.
  function automatic rights_t need_of(acc_e t);
    rights_t n;
    n = RIGHTS_NONE;
    unique case (t)
      ACC_READ:  n.r = 1'b1;
      ACC_WRITE: n.w = 1'b1;
      ACC_FETCH: n.x = 1'b1;
      default:   n = RIGHTS_NONE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/perm_pp_table.sv
module perm_pp_table
  import perm_pkg::*;
(
  input  logic       key_i,
  input  logic [2:0] code_i,
  input  logic       noexec_i,
  output rights_t    rights_o
);

  logic rd, wr;

  always_comb begin
    rd = 1'b0;
    wr = 1'b0;
    if (!key_i) begin
      unique case (code_i)
        3'd0, 3'd1, 3'd2: begin rd = 1'b1; wr = 1'b1; end
        3'd3, 3'd6:       rd = 1'b1;
        default:          ;
      endcase
    end else begin
      unique case (code_i)
        3'd2:       begin rd = 1'b1; wr = 1'b1; end
        3'd1, 3'd3: rd = 1'b1;
        default:    ;
      endcase
    end
  end

  assign rights_o = '{x: ~noexec_i, w: wr, r: rd};

  // Reserved codes never grant data access.
  always_comb begin
    if (code_i == 3'd4 || code_i == 3'd5 || code_i == 3'd7)
      AST_PP_RESERVED: assert (!rights_o.r && !rights_o.w); // R2
  end

  // Write is never granted without read.
  always_comb begin
    AST_PP_WR_IMPL_RD: assert (!rights_o.w || rights_o.r); // R3
  end

endmodule

// File: rtl/perm_mask_field.sv
module perm_mask_field
  import perm_pkg::*;
#(
  parameter int KEY_W    = 5,
  localparam int NUM_KEYS = 1 << KEY_W,
  localparam int MASK_W   = 2 * NUM_KEYS
) (
  input  logic [MASK_W-1:0] mask_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              en_i,
  output rights_t           rights_o
);

  logic [1:0] fields [NUM_KEYS];

  // Key 0 owns the most significant pair.
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_field
    assign fields[k] = mask_i[2*(NUM_KEYS-1-k) +: 2];
  end

  logic [1:0] sel;
  assign sel = fields[key_i];

  always_comb begin
    if (en_i) rights_o = '{x: 1'b1, w: sel[1], r: sel[0]};
    else      rights_o = RIGHTS_ALL;
  end

  always_comb begin
    AST_MASK_EXEC: assert (rights_o.x); // R5
  end

  always_comb begin
    if (!en_i)
      AST_MASK_OFF: assert (rights_o == RIGHTS_ALL); // R6
  end

endmodule

// File: rtl/perm_eval.sv
module perm_eval
  import perm_pkg::*;
#(
  parameter int PTE_W     = 64,
  parameter int KEY_W     = 5,
  parameter int KEY_LSB   = 9,
  parameter int NX_BIT    = 2,
  parameter int GRD_BIT   = 3,
  parameter int PP_HI_BIT = 63,
  localparam int NUM_KEYS = 1 << KEY_W,
  localparam int MASK_W   = 2 * NUM_KEYS
) (
  input  logic              prob_state_i,
  input  logic              seg_key_user_i,
  input  logic              seg_key_sup_i,
  input  logic              seg_noexec_i,
  input  logic [PTE_W-1:0]  pte_w1_i,
  input  logic [MASK_W-1:0] auth_mask_i,
  input  logic              mask_en_i,
  input  logic [1:0]        acc_type_i,
  output logic [2:0]        grant_o,
  output logic              viol_o,
  output logic              pp_fail_o,
  output logic              mask_fail_o,
  output logic              bad_type_o
);

  logic             act_key;
  logic [2:0]       pp_code;
  logic             pg_noexec;
  logic [KEY_W-1:0] pg_key;
  rights_t          pp_rights, mask_rights, fin_rights, need;
  acc_e             acc;

  assign act_key   = prob_state_i ? seg_key_user_i : seg_key_sup_i;
  assign pp_code   = {pte_w1_i[PP_HI_BIT], pte_w1_i[1:0]};
  assign pg_noexec = pte_w1_i[NX_BIT] | pte_w1_i[GRD_BIT] | seg_noexec_i;
  assign pg_key    = pte_w1_i[KEY_LSB +: KEY_W];
  assign acc       = acc_e'(acc_type_i);

  perm_pp_table u_pp (
    .key_i    (act_key),
    .code_i   (pp_code),
    .noexec_i (pg_noexec),
    .rights_o (pp_rights)
  );

  perm_mask_field #(.KEY_W(KEY_W)) u_mask (
    .mask_i   (auth_mask_i),
    .key_i    (pg_key),
    .en_i     (mask_en_i),
    .rights_o (mask_rights)
  );

  assign fin_rights  = pp_rights & mask_rights;
  assign need        = need_of(acc);
  assign bad_type_o  = (acc == ACC_BAD);
  assign pp_fail_o   = |(need & ~pp_rights);
  assign mask_fail_o = |(need & ~mask_rights);
  assign viol_o      = bad_type_o | (|(need & ~fin_rights));
  assign grant_o     = fin_rights;

  always_comb begin
    AST_GRANT_SUBSET: assert ((grant_o & ~pp_rights) == 3'b000 &&
                              (grant_o & ~mask_rights) == 3'b000); // R7
  end

  always_comb begin
    if (pg_noexec)
      AST_NO_EXEC: assert (!grant_o[2]); // R4
  end

  always_comb begin
    if (pp_fail_o || mask_fail_o)
      AST_FAIL_VIOL: assert (viol_o); // R8
  end

  always_comb begin
    if (bad_type_o)
      AST_BAD_TYPE: assert (viol_o && !pp_fail_o && !mask_fail_o); // R9
  end

endmodule

// File: tb/perm_eval_test.sv
module perm_eval_test;

  logic        clk = 1'b0;
  logic        prob_state, key_user, key_sup, seg_nx, mask_en;
  logic [63:0] pte_w1, auth_mask;
  logic [1:0]  acc_type;
  logic [2:0]  grant;
  logic        viol, pp_fail, mask_fail, bad_type;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  perm_eval uut (
    .prob_state_i   (prob_state),
    .seg_key_user_i (key_user),
    .seg_key_sup_i  (key_sup),
    .seg_noexec_i   (seg_nx),
    .pte_w1_i       (pte_w1),
    .auth_mask_i    (auth_mask),
    .mask_en_i      (mask_en),
    .acc_type_i     (acc_type),
    .grant_o        (grant),
    .viol_o         (viol),
    .pp_fail_o      (pp_fail),
    .mask_fail_o    (mask_fail),
    .bad_type_o     (bad_type)
  );

  localparam logic [63:0] USED_BITS = 64'h8000_0000_0000_3E0F;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] table_rw(logic key, logic [2:0] code);
    if (!key) begin
      if (code <= 3'd2) return 2'b11;
      if (code == 3'd3 || code == 3'd6) return 2'b01;
      return 2'b00;
    end
    if (code == 3'd2) return 2'b11;
    if (code == 3'd1 || code == 3'd3) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [63:0] make_pte(logic [2:0] code, logic n, logic g, logic [4:0] pk);
    logic [63:0] p;
    p = '0;
    p[63] = code[2];
    p[1:0] = code[1:0];
    p[2] = n;
    p[3] = g;
    p[13:9] = pk;
    return p;
  endfunction

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    prob_state = 0; key_user = 0; key_sup = 0; seg_nx = 0; mask_en = 0;
    pte_w1 = '0; auth_mask = '0; acc_type = 0;
    settle();
    // code 0, key 0, mask off: read/write/exec granted, read access ok
    check("R2", {5'd0, grant}, 8'h07);
    check("R8", {7'd0, viol}, 8'h00);

    // Phase A: exhaustive sweep of protection inputs
    for (int i = 0; i < 4096; i++) begin
      logic pr, ku, ks, snx, n, g, en;
      logic [2:0] code;
      logic [1:0] at;
      logic [4:0] pk;
      logic key;
      logic [1:0] fld;
      logic [2:0] ppr, mr, fin, need;
      {pr, ku, ks, snx, code, n, g, en, at} = i[12:0];
      pk = 5'(i * 7);
      auth_mask = 64'h9C3A_51E7_0B6D_F482 ^ {32'(i), 32'(i * 13)};
      prob_state = pr; key_user = ku; key_sup = ks; seg_nx = snx;
      mask_en = en; acc_type = at;
      pte_w1 = make_pte(code, n, g, pk);
      key = pr ? ku : ks;
      fld = 2'((auth_mask >> (2 * (31 - int'(pk)))) & 64'd3);
      ppr = {~(n | g | snx), table_rw(key, code)};
      mr = en ? {1'b1, fld} : 3'b111;
      fin = ppr & mr;
      need = (at == 2'd3) ? 3'b000 : 3'(1 << at);
      settle();
      if (!en) begin
        if (ku != ks) check("R1", {6'd0, grant[1:0]}, {6'd0, fin[1:0]});
        else if (key) check("R3", {6'd0, grant[1:0]}, {6'd0, fin[1:0]});
        else check("R2", {6'd0, grant[1:0]}, {6'd0, fin[1:0]});
        check("R6", {5'd0, grant}, {5'd0, ppr});
        check("R4", {7'd0, grant[2]}, {7'd0, ppr[2]});
      end else begin
        check("R7", {5'd0, grant}, {5'd0, fin});
      end
      if (at == 2'd3) begin
        check("R9", {4'd0, viol, pp_fail, mask_fail, bad_type}, 8'h08 | 8'h01);
      end else begin
        check("R8", {4'd0, viol, pp_fail, mask_fail, bad_type},
              {4'd0, |(need & ~fin), |(need & ~ppr), |(need & ~mr), 1'b0});
      end
    end

    // Phase B: every page key against every field value
    for (int k = 0; k < 32; k++) begin
      for (int f = 0; f < 4; f++) begin
        logic [63:0] m;
        m = '0;
        for (int j = 0; j < 32; j++) m[2*(31-j) +: 2] = (j == k) ? 2'(f) : ~2'(f);
        auth_mask = m; mask_en = 1; prob_state = 0; key_sup = 0; seg_nx = 0;
        pte_w1 = make_pte(3'd2, 1'b0, 1'b0, 5'(k)); acc_type = 2'd1;
        settle();
        check("R5", {5'd0, grant}, {5'd0, 1'b1, 2'(f)});
        check("R5", {6'd0, mask_fail, viol}, {6'd0, ~f[1], ~f[1]});
      end
    end

    // Phase C: unused entry bits are ignored
    for (int i = 0; i < 64; i++) begin
      logic [63:0] base, noise;
      logic [7:0] clean;
      base = make_pte(3'(i), i[3], i[4], 5'(i * 3));
      noise = ({32'(i * 32'h9E37_79B9), 32'(~i * 32'h85EB_CA6B)}) & ~USED_BITS;
      auth_mask = 64'h3C5A_F00F_96E1_2D78; mask_en = i[5];
      prob_state = i[0]; key_user = i[1]; key_sup = i[2]; seg_nx = 0;
      acc_type = 2'(i);
      pte_w1 = base;
      settle();
      clean = {grant, viol, pp_fail, mask_fail, bad_type};
      pte_w1 = base | noise;
      settle();
      check("R10", {grant, viol, pp_fail, mask_fail, bad_type}, clean);
    end

    summary();
  end

endmodule